// File: doc/BRIEF.md
# Configurable Interrupt Request Pin Generator

This block collects single-cycle event strobes from a set of sources into a sticky pending register and drives one interrupt request pin from it. Each pending bit has its own enable, and one global enable gates the pin as a whole. Taking the global enable away only silences the pin. Pending bits are kept, so turning the global enable back on with work still outstanding raises the request again. Software clears pending bits by writing ones.

The pin can signal in four ways. It can hold a level or emit a fixed-width pulse, and it can be active high or active low. In level mode the pin follows the combined masked request. In pulse mode every rising edge of that request produces one pulse. The pulse length is set in nanoseconds and turned into clock cycles from the clock frequency. The defaults of 48 MHz and 166 ns give 8 cycles.

Top module: `irq_pin_gen`

## Requirements
- R1: An event strobe on source i sets pending bit i at the next rising clock edge. If an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R2: When `clear_we_i` is high, each 1 in `clear_bits_i` clears the matching pending bit at the next edge. A 0 in `clear_bits_i` leaves its bit unchanged.
- R3: The pin is asserted only when some pending bit is set, that bit's enable is 1, and the global enable is 1. A pending bit whose enable is 0 never asserts the pin.
- R4: Dropping `global_en_i` deasserts the pin and leaves the pending bits unchanged. Raising it again with a bit still pending and enabled asserts the pin again.
- R5: When `pulse_mode_i`=0 (level mode), the pin is asserted in the same cycle as the masked request and stays asserted for as long as that request holds.
- R6: When `pulse_mode_i`=1 (pulse mode), each rising edge of the masked request produces a pulse. The pulse starts one clock after the edge and lasts exactly PULSE_CYCLES cycles, after which the pin goes inactive even if the request is still held.
- R7: In pulse mode, re-enabling an event that is still pending (through its enable bit or the global enable) produces a new pulse.
- R8: When `active_high_i`=1 the asserted level is 1; when it is 0 the asserted level is 0. The pin always shows the inactive level of the current polarity when it is not asserted, and it follows a polarity change in the same cycle.
- R9: PULSE_CYCLES = ceil(CLK_KHZ * PULSE_NS / 1,000,000), with a minimum of 1.
- R10: During reset and right after it, all pending bits are 0 and the pin sits at the inactive level of the current polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| event_i | input | NUM_SRC | Event strobes, one per source |
| clear_we_i | input | 1 | Qualifies a write-one-to-clear |
| clear_bits_i | input | NUM_SRC | Bits to clear when `clear_we_i` is high |
| enable_i | input | NUM_SRC | Per-source enable |
| global_en_i | input | 1 | Global pin enable |
| pulse_mode_i | input | 1 | 0 = level, 1 = pulse |
| active_high_i | input | 1 | 0 = active low, 1 = active high |
| status_o | output | NUM_SRC | Pending bits |
| irq_o | output | 1 | Interrupt request pin |

## Verification
The bench builds the block with four sources, a 50 MHz clock setting and a 60 ns pulse, which gives a 3-cycle pulse. That short pulse lets each pulse be counted edge to edge across every source and all four pin modes. The sweep covers masked and unmasked sources, global disable and re-enable, write-zero and write-one clears, event and clear arriving in the same cycle, and polarity flips while the pin is idle and while it is asserted.

// File: rtl/irq_pin_pkg.sv
package irq_pin_pkg;

  // Pulse length in clock cycles: ceiling of clock (kHz) times width (ns) / 1e6.
  function automatic int unsigned pulse_cycles(input int unsigned clk_khz,
                                               input int unsigned width_ns);
    longint unsigned prod;
    longint unsigned cyc;
    prod = longint'(clk_khz) * longint'(width_ns);
    cyc  = (prod + 64'd999_999) / 64'd1_000_000;
    if (cyc == 0) cyc = 1;
    return int'(cyc);
  endfunction

  // Pin level from the logical assert state and the polarity selection.
  function automatic logic pin_level(input logic asserted, input logic active_high);
    return active_high ? asserted : ~asserted;
  endfunction

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] event_i,
  input  logic               clear_we_i,
  input  logic [NUM_SRC-1:0] clear_bits_i,
  output logic [NUM_SRC-1:0] status_o
);

  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] clear_mask;

  assign clear_mask = clear_we_i ? clear_bits_i : '0;

  // A set arriving in the same cycle as its clear takes priority.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clear_mask) | event_i;
  end

  assign status_o = status_q;

  p_set_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|event_i) |=> ((status_o & $past(event_i)) == $past(event_i)));

  p_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_we_i |=> ((status_o & $past(clear_bits_i & ~event_i)) == '0));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_we_i && event_i == '0) |=> $stable(status_o));

endmodule

// File: rtl/irq_req_gate.sv
module irq_req_gate #(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic [NUM_SRC-1:0] status_i,
  input  logic [NUM_SRC-1:0] enable_i,
  input  logic               global_en_i,
  output logic               req_o
);

  logic [NUM_SRC-1:0] masked;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_mask
    assign masked[g] = status_i[g] & enable_i[g];
  end

  assign req_o = global_en_i & (|masked);

endmodule

// File: rtl/irq_pin_shaper.sv
module irq_pin_shaper #(
  parameter int unsigned PULSE_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic pulse_mode_i,
  input  logic active_high_i,
  output logic pulse_busy_o,
  output logic pin_o
);

  localparam int unsigned CW = $clog2(PULSE_CYCLES + 1);

  logic          req_d;
  logic          req_rise;
  logic [CW-1:0] pulse_cnt;
  logic          asserted;

  assign req_rise = req_i & ~req_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_d <= 1'b0;
    else         req_d <= req_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pulse_cnt <= '0;
    else if (!pulse_mode_i)     pulse_cnt <= '0;
    else if (req_rise)          pulse_cnt <= CW'(PULSE_CYCLES);
    else if (pulse_cnt != '0)   pulse_cnt <= pulse_cnt - CW'(1);
  end

  assign pulse_busy_o = (pulse_cnt != '0);
  assign asserted     = pulse_mode_i ? pulse_busy_o : req_i;
  assign pin_o        = irq_pin_pkg::pin_level(asserted, active_high_i);

  p_pulse_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_mode_i && req_rise) |=>
      (!pulse_mode_i || !$stable(active_high_i) || pin_o == active_high_i));

  p_pulse_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_mode_i && !pulse_busy_o) |-> (pin_o == !active_high_i));

endmodule

// File: rtl/irq_pin_gen.sv
module irq_pin_gen #(
  parameter int unsigned NUM_SRC  = 8,
  parameter int unsigned CLK_KHZ  = 48_000,
  parameter int unsigned PULSE_NS = 166
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] event_i,
  input  logic               clear_we_i,
  input  logic [NUM_SRC-1:0] clear_bits_i,
  input  logic [NUM_SRC-1:0] enable_i,
  input  logic               global_en_i,
  input  logic               pulse_mode_i,
  input  logic               active_high_i,
  output logic [NUM_SRC-1:0] status_o,
  output logic               irq_o
);

  localparam int unsigned PULSE_CYCLES = irq_pin_pkg::pulse_cycles(CLK_KHZ, PULSE_NS);

  logic masked_req;
  logic pulse_busy;

  irq_status_bank #(.NUM_SRC(NUM_SRC)) u_status (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .event_i      (event_i),
    .clear_we_i   (clear_we_i),
    .clear_bits_i (clear_bits_i),
    .status_o     (status_o)
  );

  irq_req_gate #(.NUM_SRC(NUM_SRC)) u_gate (
    .status_i    (status_o),
    .enable_i    (enable_i),
    .global_en_i (global_en_i),
    .req_o       (masked_req)
  );

  irq_pin_shaper #(.PULSE_CYCLES(PULSE_CYCLES)) u_shaper (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_i         (masked_req),
    .pulse_mode_i  (pulse_mode_i),
    .active_high_i (active_high_i),
    .pulse_busy_o  (pulse_busy),
    .pin_o         (irq_o)
  );

  p_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pulse_mode_i && irq_o == active_high_i) |->
      (global_en_i && (status_o & enable_i) != '0));

  p_level_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pulse_mode_i && global_en_i && (status_o & enable_i) != '0) |->
      (irq_o == active_high_i));

  p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!global_en_i || (status_o & enable_i) == '0) && !pulse_busy) |->
      (irq_o == !active_high_i));

endmodule

// File: tb/test_irq_pin_gen.sv
module test_irq_pin_gen;

  localparam int NS       = 4;
  localparam int CLK_KHZ  = 50_000;
  localparam int PULSE_NS = 60;
  localparam int EXP_P    = (CLK_KHZ * PULSE_NS + 999_999) / 1_000_000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] evt, clr_bits, en, status;
  logic          clr_we, glob, pmode, act_hi, irq;

  int errs   = 0;
  int checks = 0;

  always #10 clk = ~clk;

  irq_pin_gen #(.NUM_SRC(NS), .CLK_KHZ(CLK_KHZ), .PULSE_NS(PULSE_NS)) i_irq_pin_gen (
    .clk_i(clk), .rst_ni(rst_n), .event_i(evt), .clear_we_i(clr_we),
    .clear_bits_i(clr_bits), .enable_i(en), .global_en_i(glob),
    .pulse_mode_i(pmode), .active_high_i(act_hi), .status_o(status), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #2;
  endtask

  // Counts asserted cycles over a window that starts one tick after the triggering edge.
  task automatic count_pulse(input logic hi, output int n);
    n = 0;
    for (int k = 0; k < EXP_P + 3; k++) begin
      tick();
      if (irq === hi) n++;
    end
  endtask

  initial begin
    #(20 * 200_000);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; evt = '0; clr_we = 1'b0; clr_bits = '0; en = '0;
    glob = 1'b0; pmode = 1'b0; act_hi = 1'b0;
    tick();
    chk("R10 status in reset", status, 0);
    chk("R10 idle pin low-active", irq, 1);
    act_hi = 1'b1; #1;
    chk("R8 idle pin follows polarity in reset", irq, 0);
    tick();
    rst_n = 1'b1;
    tick();
    chk("R10 status after reset", status, 0);
    chk("R9 pulse length arithmetic", EXP_P, 3);

    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < NS; s++) begin
        logic pm, hi;
        int other;
        pm = m[1]; hi = m[0]; other = (s + 1) % NS;
        evt = '0; clr_we = 1'b1; clr_bits = '1; en = NS'(1) << s; glob = 1'b1;
        pmode = pm; act_hi = hi;
        tick();
        clr_we = 1'b0;
        repeat (EXP_P + 2) tick();
        chk("R8 idle level", irq, !hi);

        // Masked source must not assert the pin.
        evt = NS'(1) << other;
        tick();
        evt = '0;
        chk("R1 masked source captured", status, NS'(1) << other);
        chk("R3 masked source pin", irq, !hi);
        repeat (EXP_P + 1) tick();
        chk("R3 masked source pin later", irq, !hi);
        clr_we = 1'b1; clr_bits = NS'(1) << other;
        tick();
        clr_we = 1'b0;
        chk("R2 masked source cleared", status, 0);

        // Enabled source.
        evt = NS'(1) << s;
        tick();
        evt = '0;
        chk("R1 enabled source captured", status, NS'(1) << s);
        if (!pm) begin
          chk("R5 level asserts", irq, hi);
          repeat (3) begin
            tick();
            chk("R5 level holds", irq, hi);
          end
        end else begin
          chk("R6 pulse not before edge+1", irq, !hi);
          count_pulse(hi, n);
          chk("R6 pulse width", n, EXP_P);
          chk("R6 pulse ended with request held", irq, !hi);
        end

        // Global gating.
        glob = 1'b0; #1;
        chk("R4 global off deasserts", irq, !hi);
        chk("R4 global off keeps status", status, NS'(1) << s);
        tick();
        chk("R4 global off stays off", irq, !hi);
        glob = 1'b1; #1;
        if (!pm) chk("R4 re-enable reasserts", irq, hi);
        else begin
          count_pulse(hi, n);
          chk("R7 re-enable new pulse", n, EXP_P);
        end

        // Re-enable through the per-source enable in pulse mode.
        if (pm) begin
          en = '0;
          tick();
          en = NS'(1) << s;
          count_pulse(hi, n);
          chk("R7 source re-enable new pulse", n, EXP_P);
        end else begin
          act_hi = !hi; #1;
          chk("R8 asserted level follows polarity", irq, !hi);
          act_hi = hi; #1;
        end

        // Write zero has no effect.
        clr_we = 1'b1; clr_bits = '0;
        tick();
        clr_we = 1'b0;
        chk("R2 write zero keeps status", status, NS'(1) << s);

        // Event and clear on the same bit in one cycle.
        clr_we = 1'b1; clr_bits = NS'(1) << s; evt = NS'(1) << s;
        tick();
        evt = '0;
        chk("R1 set beats clear", status, NS'(1) << s);

        tick();
        clr_we = 1'b0;
        chk("R2 write one clears", status, 0);
        chk("R3 pin inactive after clear", irq, !hi);

        act_hi = !hi; #1;
        chk("R8 idle follows polarity change", irq, hi);
        act_hi = hi; #1;
      end
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule